// File: doc/BRIEF.md
# Encoder Position Counter with Error Check

This block keeps a 16-bit signed-agnostic position count for an incremental encoder. An upstream edge decoder supplies a single-cycle count pulse, a direction level and a qualified index pulse. The block only turns these into a position. Whether two or four counts arrive per encoder line is settled upstream, so both resolutions behave the same here.

A three-bit mode input enables the counter and picks how the count is brought back to a known value. In the index-reset style, an index pulse clears the count when the clear enable is high. In this style the block also watches for a count that leaves the expected range, and it latches a sticky error flag with an optional one-cycle error interrupt. In the maximum-match style, the count runs between zero and a programmable maximum. It wraps in both directions and raises no error. Every index pulse in an active mode gives an index strobe, whether or not it changed the count.

Top module: `enc_pos_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pos_cnt` becomes 0 and `idx_irq`, `cnt_err` and `err_irq` become 0.
- R2: In index-reset style (`mode` = 3'b100 or 3'b110), a count pulse changes `pos_cnt` at the next edge by +1 when `cnt_up` = 1 and by -1 when `cnt_up` = 0. The count wraps naturally at 16 bits.
- R3: When `mode[2]` = 0, `pos_cnt` holds its value. Count pulses and index pulses are ignored, and `idx_irq` stays 0.
- R4: In index-reset style, an index pulse with `idx_rst_en` = 1 makes `pos_cnt` 0 at the next edge, and this takes priority over a count pulse in the same cycle. With `idx_rst_en` = 0, the index pulse leaves counting unaffected.
- R5: In any active mode (`mode[2]` = 1), each cycle with `idx_pulse` = 1 gives `idx_irq` = 1 in the following cycle, lasting one cycle.
- R6: In maximum-match style (`mode` = 3'b101 or 3'b111), an up-count from `max_cnt` gives 0 and a down-count from 0 gives `max_cnt`. Other counts step by one, and index pulses do not change the count.
- R7: In index-reset style, a count pulse whose result is `max_cnt`+1 (mod 2^16) while counting up, or 16'hFFFF while counting down, sets `cnt_err` at the same edge that updates `pos_cnt`.
- R8: No error is flagged in maximum-match or inactive modes. A natural wrap that does not land on the bound of R7 raises no `err_irq`.
- R9: `err_irq` pulses for one cycle together with each error detection when `err_irq_mask` = 0. It stays 0 when `err_irq_mask` = 1, and `cnt_err` is still set in that case.
- R10: `cnt_err` stays set until a cycle with `err_clr` = 1 clears it. An error detection in that same cycle wins over the clear.
- R11: Counting continues normally after an error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | 1x0 index-reset style, 1x1 maximum-match style, 0xx hold |
| idx_rst_en | input | 1 | Index pulse clears the count (index-reset style only) |
| max_cnt | input | 16 | Programmable maximum count |
| cnt_pulse | input | 1 | One-cycle count request |
| cnt_up | input | 1 | Direction: 1 up, 0 down |
| idx_pulse | input | 1 | Qualified index pulse |
| err_irq_mask | input | 1 | Suppresses the error interrupt |
| err_clr | input | 1 | Software clear of the error flag |
| pos_cnt | output | 16 | Position count |
| idx_irq | output | 1 | Index interrupt strobe |
| cnt_err | output | 1 | Sticky count error flag |
| err_irq | output | 1 | Error interrupt strobe |

## Verification
Directed sequences first walk the count across its edges. They cover a down-step from zero in index style, which hits the all-ones bound, and an up-step onto max+1. They also cover both wraps in maximum-match style and an up-wrap from all-ones to zero, which must stay silent. These separate the two error bounds from each other and from plain wraparound. Index pulses are given with and without the clear enable, and together with count pulses, to show the clear priority and that the strobe is independent of the clear. Random runs then mix all eight mode codes, small maximum values, masks and clears, so that wraps, bound hits and set-versus-clear collisions occur often. Each cycle is compared with a reference model written from the requirements.

// File: rtl/enc_pos_pkg.sv
// Package: shared types for the encoder position counter.
// Assumes: mode codes follow the three-bit encoding listed in the brief.
package enc_pos_pkg;

    typedef enum logic [1:0] {
        STYLE_HOLD = 2'd0,
        STYLE_IDX  = 2'd1,
        STYLE_MAX  = 2'd2
    } style_e;

    // Maps a raw mode code to a counting style (resolution bit is upstream's concern).
    function automatic style_e decode_style(input logic [2:0] code);
        style_e s;
        case (code)
            3'b100, 3'b110: s = STYLE_IDX;
            3'b101, 3'b111: s = STYLE_MAX;
            default:        s = STYLE_HOLD;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/enc_mode_decode.sv
// Module: enc_mode_decode
// Turns the raw mode input into a counting style.
// Assumes: the mode input is static or changes only between count events.
module enc_mode_decode
    import enc_pos_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic [MODE_W-1:0] mode,
    output style_e            style
);

    // Purpose: pure decode of the style from the mode code.
    always_comb begin
        style = decode_style(mode[2:0]);
    end

endmodule

// File: rtl/enc_count_core.sv
// Module: enc_count_core
// Holds the position register, applies count steps, index clears and
// maximum-match wraps, and reports when an index-style step lands on
// the out-of-range bound.
// Assumes: cnt_pulse and idx_pulse are already single-cycle and synchronous.
module enc_count_core
    import enc_pos_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  style_e           style,
    input  logic             cnt_pulse,
    input  logic             cnt_up,
    input  logic             idx_pulse,
    input  logic             idx_rst_en,
    input  logic [CNT_W-1:0] max_cnt,
    output logic [CNT_W-1:0] pos_cnt,
    output logic             idx_irq,
    output logic             bound_hit
);

    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ALL1 = '1;

    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] step_val;
    logic [CNT_W-1:0] bound_val;
    logic             idx_clear;

    // Purpose: plain +/-1 step and the direction-dependent error bound.
    always_comb begin
        step_val  = cnt_up ? pos_cnt + ONE : pos_cnt - ONE;
        bound_val = cnt_up ? max_cnt + ONE : ALL1;
        idx_clear = (style == STYLE_IDX) && idx_pulse && idx_rst_en;
    end

    // Purpose: select the next count and flag a bound hit for this cycle.
    always_comb begin
        cnt_nxt   = pos_cnt;
        bound_hit = 1'b0;
        case (style)
            STYLE_IDX: begin
                if (idx_clear) begin
                    cnt_nxt = ZERO;
                end else if (cnt_pulse) begin
                    cnt_nxt   = step_val;
                    bound_hit = (step_val == bound_val);
                end
            end
            STYLE_MAX: begin
                if (cnt_pulse) begin
                    if (cnt_up)
                        cnt_nxt = (pos_cnt == max_cnt) ? ZERO : step_val;
                    else
                        cnt_nxt = (pos_cnt == ZERO) ? max_cnt : step_val;
                end
            end
            default: cnt_nxt = pos_cnt;
        endcase
    end

    // Purpose: position register and index strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_cnt <= ZERO;
            idx_irq <= 1'b0;
        end else begin
            pos_cnt <= cnt_nxt;
            idx_irq <= (style != STYLE_HOLD) && idx_pulse;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (style == STYLE_HOLD) |=> (pos_cnt == $past(pos_cnt))); // R3
    AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (style == STYLE_IDX && idx_pulse && idx_rst_en) |=> (pos_cnt == ZERO)); // R4
    AST_IDX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (style != STYLE_HOLD && idx_pulse) |=> idx_irq); // R5
    AST_MAX_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (style == STYLE_MAX && cnt_pulse && cnt_up && pos_cnt == max_cnt) |=> (pos_cnt == ZERO)); // R6
    AST_MAX_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (style == STYLE_MAX && cnt_pulse && !cnt_up && pos_cnt == ZERO) |=> (pos_cnt == $past(max_cnt))); // R6

endmodule

// File: rtl/enc_err_monitor.sv
// Module: enc_err_monitor
// Keeps the sticky count error flag and issues the maskable error strobe.
// Assumes: bound_hit is a one-cycle indication from the count core.
module enc_err_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic bound_hit,
    input  logic err_irq_mask,
    input  logic err_clr,
    output logic cnt_err,
    output logic err_irq
);

    // Purpose: sticky flag (set wins over clear) and masked strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_err <= 1'b0;
            err_irq <= 1'b0;
        end else begin
            cnt_err <= bound_hit || (cnt_err && !err_clr);
            err_irq <= bound_hit && !err_irq_mask;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_err && !err_clr) |=> cnt_err); // R10
    AST_ERR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_mask |=> !err_irq); // R9
    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> cnt_err); // R9

endmodule

// File: rtl/enc_pos_counter.sv
// Module: enc_pos_counter (top)
// Position counter for an incremental encoder: decodes the mode, runs the
// count core and the error monitor.
// Assumes: inputs are synchronous to clk; reset is synchronous, active low.
module enc_pos_counter
    import enc_pos_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              idx_rst_en,
    input  logic [CNT_W-1:0]  max_cnt,
    input  logic              cnt_pulse,
    input  logic              cnt_up,
    input  logic              idx_pulse,
    input  logic              err_irq_mask,
    input  logic              err_clr,
    output logic [CNT_W-1:0]  pos_cnt,
    output logic              idx_irq,
    output logic              cnt_err,
    output logic              err_irq
);

    style_e style;
    logic   bound_hit;

    enc_mode_decode #(.MODE_W(MODE_W)) u_dec (
        .mode  (mode),
        .style (style)
    );

    enc_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .style      (style),
        .cnt_pulse  (cnt_pulse),
        .cnt_up     (cnt_up),
        .idx_pulse  (idx_pulse),
        .idx_rst_en (idx_rst_en),
        .max_cnt    (max_cnt),
        .pos_cnt    (pos_cnt),
        .idx_irq    (idx_irq),
        .bound_hit  (bound_hit)
    );

    enc_err_monitor u_err (
        .clk          (clk),
        .rst_n        (rst_n),
        .bound_hit    (bound_hit),
        .err_irq_mask (err_irq_mask),
        .err_clr      (err_clr),
        .cnt_err      (cnt_err),
        .err_irq      (err_irq)
    );

    AST_IDX_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode[2:0] == 3'b100 || mode[2:0] == 3'b110) && cnt_pulse && cnt_up && !idx_pulse)
        |=> (pos_cnt == CNT_W'($past(pos_cnt) + CNT_W'(1)))); // R2
    AST_NO_ERR_OUTSIDE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        !(mode[2:0] == 3'b100 || mode[2:0] == 3'b110) |=> !err_irq); // R8

endmodule

// File: tb/enc_pos_counter_test.sv
`timescale 1ns/1ps
module enc_pos_counter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = '0;
    logic        idx_rst_en = 1'b0;
    logic [15:0] max_cnt = '0;
    logic        cnt_pulse = 1'b0;
    logic        cnt_up = 1'b0;
    logic        idx_pulse = 1'b0;
    logic        err_irq_mask = 1'b0;
    logic        err_clr = 1'b0;
    logic [15:0] pos_cnt;
    logic        idx_irq, cnt_err, err_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    logic [15:0] m_cnt = '0;
    logic        m_err = 1'b0, m_eirq = 1'b0, m_iirq = 1'b0;
    string       t_cnt, t_err, t_eirq;

    always #2 clk = ~clk;

    enc_pos_counter uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .idx_rst_en(idx_rst_en),
        .max_cnt(max_cnt), .cnt_pulse(cnt_pulse), .cnt_up(cnt_up),
        .idx_pulse(idx_pulse), .err_irq_mask(err_irq_mask), .err_clr(err_clr),
        .pos_cnt(pos_cnt), .idx_irq(idx_irq), .cnt_err(cnt_err), .err_irq(err_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model of one clock edge, written from the requirements.
    task automatic model_step();
        logic act, idxs, hit;
        logic [15:0] nxt;
        act  = mode[2];
        idxs = act && !mode[0];
        hit  = 1'b0;
        nxt  = m_cnt;
        t_cnt = "R2";
        if (!act) t_cnt = "R3";
        else if (idxs) begin
            if (idx_pulse && idx_rst_en) begin nxt = 16'h0; t_cnt = "R4"; end
            else if (cnt_pulse) begin
                nxt = cnt_up ? m_cnt + 16'd1 : m_cnt - 16'd1;
                hit = (nxt == (cnt_up ? max_cnt + 16'd1 : 16'hFFFF));
                if (m_err) t_cnt = "R11";
            end
        end else begin
            t_cnt = "R6";
            if (cnt_pulse) begin
                if (cnt_up) nxt = (m_cnt == max_cnt) ? 16'h0 : m_cnt + 16'd1;
                else        nxt = (m_cnt == 16'h0) ? max_cnt : m_cnt - 16'd1;
            end
        end
        t_err  = hit ? "R7" : (idxs ? "R10" : "R8");
        t_eirq = err_irq_mask ? "R9" : (hit ? "R7" : "R8");
        m_iirq = act && idx_pulse;
        m_eirq = hit && !err_irq_mask;
        m_err  = hit || (m_err && !err_clr);
        m_cnt  = nxt;
    endtask

    // Entered at a negedge: drive, advance one edge, compare at the next negedge.
    task automatic step(input logic [2:0] md, input logic cp, input logic up,
                        input logic ip, input logic en, input logic msk, input logic clr);
        mode = md; cnt_pulse = cp; cnt_up = up; idx_pulse = ip;
        idx_rst_en = en; err_irq_mask = msk; err_clr = clr;
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk(t_cnt, pos_cnt, m_cnt);
        chk("R5", {15'd0, idx_irq}, {15'd0, m_iirq});
        chk(t_err, {15'd0, cnt_err}, {15'd0, m_err});
        chk(t_eirq, {15'd0, err_irq}, {15'd0, m_eirq});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", pos_cnt, 16'h0);
        chk("R1", {13'd0, idx_irq, cnt_err, err_irq}, 16'h0);
        rst_n = 1'b1;
        max_cnt = 16'h1234;

        // R2: three up steps
        repeat (3) step(3'b100, 1, 1, 0, 0, 0, 0);
        chk("R2", pos_cnt, 16'd3);
        // R3: inactive mode ignores pulses
        step(3'b010, 1, 1, 1, 1, 0, 0);
        chk("R3", pos_cnt, 16'd3);
        chk("R3", {15'd0, idx_irq}, 16'd0);
        // R4: index without enable keeps counting; with enable clears over a count
        step(3'b110, 1, 1, 1, 0, 0, 0);
        chk("R4", pos_cnt, 16'd4);
        step(3'b110, 1, 1, 1, 1, 0, 0);
        chk("R4", pos_cnt, 16'd0);
        chk("R5", {15'd0, idx_irq}, 16'd1);
        // R7: down from zero reaches all-ones bound
        step(3'b110, 1, 0, 0, 0, 0, 0);
        chk("R7", pos_cnt, 16'hFFFF);
        chk("R7", {15'd0, cnt_err}, 16'd1);
        chk("R9", {15'd0, err_irq}, 16'd1);
        // R11 / R10: counting goes on, flag stays
        step(3'b110, 1, 0, 0, 0, 0, 0);
        chk("R11", pos_cnt, 16'hFFFE);
        chk("R10", {15'd0, cnt_err}, 16'd1);
        chk("R9", {15'd0, err_irq}, 16'd0);
        step(3'b110, 0, 0, 0, 0, 0, 1);
        chk("R10", {15'd0, cnt_err}, 16'd0);
        // R8: up wrap from all-ones is silent
        step(3'b100, 1, 1, 0, 0, 0, 0);
        step(3'b100, 1, 1, 0, 0, 0, 0);
        chk("R8", pos_cnt, 16'h0);
        chk("R8", {15'd0, cnt_err}, 16'd0);
        // R7/R9: up onto max+1, masked
        max_cnt = 16'd5;
        repeat (5) step(3'b100, 1, 1, 0, 0, 1, 0);
        step(3'b100, 1, 1, 0, 0, 1, 0);
        chk("R7", pos_cnt, 16'd6);
        chk("R9", {15'd0, cnt_err, err_irq}, 16'b10);
        // R10: set and clear together, set wins
        step(3'b100, 1, 0, 0, 0, 0, 0);
        step(3'b100, 1, 1, 0, 0, 0, 1);
        chk("R10", {15'd0, cnt_err}, 16'd1);
        step(3'b100, 0, 0, 0, 0, 0, 1);
        // R6: maximum-match wraps, index ignored for count
        step(3'b101, 0, 0, 1, 1, 0, 0);
        chk("R6", pos_cnt, 16'd6);
        chk("R5", {15'd0, idx_irq}, 16'd1);
        step(3'b111, 1, 0, 0, 0, 0, 0);
        step(3'b111, 1, 1, 0, 0, 0, 0);
        chk("R6", pos_cnt, 16'd0);
        step(3'b111, 1, 0, 0, 0, 0, 0);
        chk("R6", pos_cnt, 16'd5);
        chk("R8", {15'd0, cnt_err}, 16'd0);

        // Random phase
        for (int i = 0; i < 6000; i++) begin
            if (i % 150 == 0) max_cnt = 16'($urandom % 12);
            if (i % 40 == 0) mode = 3'($urandom % 8);
            step(mode, ($urandom % 4) != 0, ($urandom % 3) != 0,
                 ($urandom % 17) == 0, $urandom % 2, ($urandom % 4) == 0,
                 ($urandom % 9) == 0);
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule